// File: doc/BRIEF.md
# Booth-Recoded Multiply-Accumulate Datapath

This block multiplies two signed 32-bit operands and adds the product into a 72-bit running sum, accepting a new operand pair on every clock. The multiplier operand is recoded into signed radix-4 digits, one digit per pair of bits. Each digit selects zero, one or two times the multiplicand, possibly negated, as a partial-product row. The rows are reduced by a tree of 3:2 carry-save compressors to one sum vector and one carry vector.

The registered accumulator value is not added to a finished product. It joins the sum and carry vectors as the third input of one last 3:2 compressor. A single parallel-prefix carry-propagate adder then resolves the result, which is written back into the accumulator. A synchronous clear empties the accumulator, and an enable decides whether a given cycle accumulates. The 72-bit width leaves eight guard bits above a full 64-bit product. Beyond that, the sum wraps modulo 2^72.

Top module: `booth_mac`

## Requirements
- R1: While `rst_n` is low, the accumulator is forced to zero at every rising clock edge, and `acc_o` reads zero from the first edge after reset is asserted.
- R2: When `clr_i` is high at a rising edge, `acc_o` becomes zero after that edge, whatever `en_i`, `a_i` and `b_i` are.
- R3: When `clr_i` and `en_i` are both low at a rising edge, `acc_o` keeps its value, and `a_i` and `b_i` have no effect.
- R4: When `en_i` is high and `clr_i` is low at a rising edge, `acc_o` becomes its previous value plus the product of `a_i` and `b_i`. Both operands are two's complement, and the product is sign-extended to 72 bits.
- R5: The extreme operands are exact: (-2^31)·(-2^31) adds 2^62, and (-2^31)·(2^31-1) adds -(2^62-2^31).
- R6: The accumulator wraps modulo 2^72. A sum that passes 2^71-1 continues from the most negative 72-bit value with no saturation.
- R7: A new operand pair is accepted on every enabled cycle. Back-to-back accumulations each show their effect on `acc_o` one cycle after their edge.
- R8: Products are exact for multiplier bit patterns that produce every radix-4 digit value (0, ±1, ±2). These include alternating bits, runs of ones and an all-ones multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Accumulate the current product on this edge |
| clr_i | input | 1 | Zero the accumulator on this edge; wins over `en_i` |
| a_i | input | 32 | Signed multiplicand |
| b_i | input | 32 | Signed multiplier, Booth recoded |
| acc_o | output | 72 | Registered accumulator value |

## Verification
The accumulator is the only state, and every value it holds is visible on `acc_o` one cycle after the edge that wrote it. A wrong digit decode, a missing negation correction, a misplaced carry or a bad prefix term therefore appears in the very next sample. Because the value is accumulated, the error then stays in every later sample until a clear. Comparing the output against a reference sum after each edge pins any fault to the operand pair that caused it. Directed patterns on the multiplier and the extreme operands reach digit codes and carry chains that random operands seldom hit.

// File: rtl/booth_mac_pkg.sv
// Shared types and helpers for the Booth multiply-accumulate datapath.
// Assumes the multiplier width is even.
package booth_mac_pkg;

    // Signed radix-4 digit selected by one overlapping group of three multiplier bits.
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } booth_digit_e;

    // Map a three-bit group {high, mid, low} to its digit.
    function automatic booth_digit_e booth_decode(input logic [2:0] grp);
        case (grp)
            3'b001, 3'b010: return DIG_POS1;
            3'b011:         return DIG_POS2;
            3'b100:         return DIG_NEG2;
            3'b101, 3'b110: return DIG_NEG1;
            default:        return DIG_ZERO;
        endcase
    endfunction

    // Number of 3:2 levels that a Wallace-style reduction of n rows to two needs.
    function automatic int csa_levels(input int n);
        int rows;
        int lv;
        rows = n;
        lv   = 0;
        while (rows > 2) begin
            rows = (rows / 3) * 2 + (rows % 3);
            lv++;
        end
        return lv;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
// Recodes a signed multiplier into radix-4 Booth digits.
// An implicit zero sits below bit 0, and the operand is sign-extended above its top bit.
// Assumes B_W is even; produces B_W/2 + 1 digits, the last one a sign group.
module booth_recoder
    import booth_mac_pkg::*;
#(
    parameter int B_W    = 32,
    parameter int NUM_PP = B_W / 2 + 1
) (
    input  logic [B_W-1:0]                  mult_i,
    output booth_digit_e [NUM_PP-1:0]       digit_o
);
    localparam int BX_W = 2 * NUM_PP + 1;

    logic [BX_W-1:0] mult_x;

    // Extend the multiplier: zero below, sign copies above.
    assign mult_x = {{(BX_W - B_W - 1){mult_i[B_W-1]}}, mult_i, 1'b0};

    for (genvar gi = 0; gi < NUM_PP; gi++) begin : g_grp
        // Decode the overlapping three-bit group for digit gi.
        assign digit_o[gi] = booth_decode(mult_x[2*gi+2 : 2*gi]);
    end

endmodule

// File: rtl/booth_pp_rows.sv
// Builds shifted, sign-extended partial-product rows from the Booth digits.
// A negative digit inverts its multiple. The +1 that completes the negation is
// collected for all rows into one extra correction row at bit 2*i.
// All rows are ACC_W wide; arithmetic is modulo 2^ACC_W.
module booth_pp_rows
    import booth_mac_pkg::*;
#(
    parameter int A_W    = 32,
    parameter int NUM_PP = 17,
    parameter int ACC_W  = 72,
    parameter int NUM_ROWS = NUM_PP + 1
) (
    input  logic [A_W-1:0]              mcand_i,
    input  booth_digit_e [NUM_PP-1:0]   digit_i,
    output logic [ACC_W-1:0]            row_o [NUM_ROWS]
);
    logic [ACC_W-1:0] mc_x1;
    logic [ACC_W-1:0] mc_x2;
    logic [ACC_W-1:0] corr_row;

    // Sign-extended one and two times the multiplicand.
    assign mc_x1 = {{(ACC_W - A_W){mcand_i[A_W-1]}}, mcand_i};
    assign mc_x2 = {mc_x1[ACC_W-2:0], 1'b0};

    for (genvar gi = 0; gi < NUM_PP; gi++) begin : g_row
        logic [ACC_W-1:0] mult_sel;
        logic             neg;

        // Pick the multiple for this digit, inverted when the digit is negative.
        always_comb begin
            neg = 1'b0;
            case (digit_i[gi])
                DIG_POS1: mult_sel = mc_x1;
                DIG_POS2: mult_sel = mc_x2;
                DIG_NEG1: begin mult_sel = ~mc_x1; neg = 1'b1; end
                DIG_NEG2: begin mult_sel = ~mc_x2; neg = 1'b1; end
                default:  mult_sel = '0;
            endcase
        end

        assign row_o[gi]        = mult_sel << (2 * gi);
        assign corr_row[2 * gi] = neg;
        if (2 * gi + 1 < ACC_W) begin : g_gap
            assign corr_row[2 * gi + 1] = 1'b0;
        end
    end

    if (2 * NUM_PP < ACC_W) begin : g_corr_hi
        assign corr_row[ACC_W-1 : 2*NUM_PP] = '0;
    end

    assign row_o[NUM_PP] = corr_row;

endmodule

// File: rtl/csa_tree.sv
// Wallace-style reduction of NUM_ROWS operands to a sum and a carry vector
// using layers of 3:2 counters. Carries are shifted left and truncated to W.
// Sum + carry equals the sum of all inputs modulo 2^W.
module csa_tree
    import booth_mac_pkg::*;
#(
    parameter int W        = 72,
    parameter int NUM_ROWS = 18
) (
    input  logic [W-1:0] row_i [NUM_ROWS],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    localparam int LEVELS = csa_levels(NUM_ROWS);

    logic [W-1:0] work [NUM_ROWS];
    logic [W-1:0] nxt  [NUM_ROWS];

    // Apply one 3:2 layer per level until two rows remain.
    always_comb begin
        int cnt;
        int m;
        cnt = NUM_ROWS;
        for (int r = 0; r < NUM_ROWS; r++) begin
            work[r] = row_i[r];
            nxt[r]  = '0;
        end
        for (int lv = 0; lv < LEVELS; lv++) begin
            m = 0;
            for (int r = 0; r < NUM_ROWS; r++) nxt[r] = '0;
            for (int j = 0; j < NUM_ROWS; j += 3) begin
                if (j + 2 < cnt) begin
                    nxt[m]     = work[j] ^ work[j+1] ^ work[j+2];
                    nxt[m + 1] = ((work[j] & work[j+1]) | (work[j] & work[j+2])
                                 | (work[j+1] & work[j+2])) << 1;
                    m = m + 2;
                end else if (j < cnt) begin
                    nxt[m] = work[j];
                    m = m + 1;
                    if (j + 1 < cnt) begin
                        nxt[m] = work[j+1];
                        m = m + 1;
                    end
                end
            end
            cnt = m;
            for (int r = 0; r < NUM_ROWS; r++) work[r] = nxt[r];
        end
        sum_o   = work[0];
        carry_o = (NUM_ROWS > 1) ? work[1] : '0;
    end

endmodule

// File: rtl/prefix_adder.sv
// Kogge-Stone parallel-prefix adder, W bits, no carry in or out.
// Depth is log2(W) prefix levels plus the final XOR.
module prefix_adder #(
    parameter int W = 72
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);
    localparam int LV = $clog2(W);

    logic [LV:0][W-1:0] gen;
    logic [LV:0][W-1:0] prp;

    // Bitwise generate and propagate.
    assign gen[0] = x_i & y_i;
    assign prp[0] = x_i ^ y_i;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= (1 << l)) begin : g_merge
                assign gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][i - (1 << l)]);
                assign prp[l+1][i] = prp[l][i] & prp[l][i - (1 << l)];
            end else begin : g_pass
                assign gen[l+1][i] = gen[l][i];
                assign prp[l+1][i] = prp[l][i];
            end
        end
    end

    // Sum bit i uses the group carry out of bits below i.
    assign s_o = prp[0] ^ {gen[LV][W-2:0], 1'b0};

endmodule

// File: rtl/booth_mac.sv
// Signed multiply-accumulate with one operand pair per cycle.
// Flow: Booth recode -> partial-product rows -> carry-save tree ->
// 3:2 merge with the accumulator -> prefix adder -> accumulator register.
// Synchronous active-low reset; clear wins over enable; wraps modulo 2^ACC_W.
module booth_mac
    import booth_mac_pkg::*;
#(
    parameter int A_W   = 32,
    parameter int B_W   = 32,
    parameter int ACC_W = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [A_W-1:0]   a_i,
    input  logic [B_W-1:0]   b_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int NUM_PP   = B_W / 2 + 1;
    localparam int NUM_ROWS = NUM_PP + 1;

    booth_digit_e [NUM_PP-1:0] digits;
    logic [ACC_W-1:0]          rows [NUM_ROWS];
    logic [ACC_W-1:0]          tree_sum;
    logic [ACC_W-1:0]          tree_cry;
    logic [ACC_W-1:0]          mrg_sum;
    logic [ACC_W-1:0]          mrg_cry;
    logic [ACC_W-1:0]          acc_next;
    logic [ACC_W-1:0]          acc_q;

    booth_recoder #(.B_W(B_W), .NUM_PP(NUM_PP)) u_recode (
        .mult_i  (b_i),
        .digit_o (digits)
    );

    booth_pp_rows #(.A_W(A_W), .NUM_PP(NUM_PP), .ACC_W(ACC_W),
                    .NUM_ROWS(NUM_ROWS)) u_rows (
        .mcand_i (a_i),
        .digit_i (digits),
        .row_o   (rows)
    );

    csa_tree #(.W(ACC_W), .NUM_ROWS(NUM_ROWS)) u_tree (
        .row_i   (rows),
        .sum_o   (tree_sum),
        .carry_o (tree_cry)
    );

    // Merge the product's two vectors with the accumulator in one 3:2 layer.
    always_comb begin
        mrg_sum = tree_sum ^ tree_cry ^ acc_q;
        mrg_cry = ((tree_sum & tree_cry) | (tree_sum & acc_q) | (tree_cry & acc_q)) << 1;
    end

    prefix_adder #(.W(ACC_W)) u_cpa (
        .x_i (mrg_sum),
        .y_i (mrg_cry),
        .s_o (acc_next)
    );

    // Accumulator register: reset, then clear, then enabled update.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else if (en_i)  acc_q <= acc_next;
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/booth_mac_chk.sv
// Property checker for booth_mac, attached by bind. It observes ports only.
module booth_mac_chk #(
    parameter int A_W   = 32,
    parameter int B_W   = 32,
    parameter int ACC_W = 72
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             clr_i,
    input logic [A_W-1:0]   a_i,
    input logic [B_W-1:0]   b_i,
    input logic [ACC_W-1:0] acc_o
);
    logic signed [A_W+B_W-1:0] prod;
    logic [ACC_W-1:0]          prod_x;

    // Reference product, sign-extended to the accumulator width.
    assign prod   = $signed(a_i) * $signed(b_i);
    assign prod_x = {{(ACC_W - A_W - B_W){prod[A_W+B_W-1]}}, prod};

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> acc_o == '0);

    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_o == '0);

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(acc_o));

    // Also covers modulo wraparound (R6) and back-to-back issue (R7).
    assert_accumulate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> acc_o == $past(acc_o) + $past(prod_x));

endmodule

bind booth_mac booth_mac_chk #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/booth_mac_tb.sv
// Bench for booth_mac: behavioural reference sum compared after every edge.
module booth_mac_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [71:0] acc_o;

    logic [71:0] model = '0;
    int          n_chk = 0;
    int          n_bad = 0;

    booth_mac u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .clr_i (clr_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .acc_o (acc_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req);
        n_chk++;
        if (acc_o !== model) begin
            n_bad++;
            $display("FAIL %s: acc=%h expected=%h", req, acc_o, model);
        end
    endtask

    // One edge: drive inputs, update reference at the edge, compare at negedge.
    task automatic step(input logic e, input logic c, input logic [31:0] av,
                        input logic [31:0] bv, input string req);
        logic signed [63:0] p;
        en_i = e; clr_i = c; a_i = av; b_i = bv;
        @(posedge clk);
        p = $signed(av) * $signed(bv);
        if (c)      model = '0;
        else if (e) model = model + {{8{p[63]}}, p};
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: acc=%h expected=finish", acc_o);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] pats [8];
        pats = '{32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 32'h3333_3333,
                 32'hCCCC_CCCC, 32'h0F0F_F0F0, 32'h8000_0001, 32'h7FFF_FFFF};

        // R1: reset state
        repeat (2) @(negedge clk);
        model = '0;
        check("R1");
        rst_n = 1'b1;

        // R4 / R7: back-to-back random accumulations
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, $urandom, $urandom, "R4_R7");
        step(1'b1, 1'b0, 32'd3, 32'hFFFF_FFFB, "R4");

        // R3: idle cycles with busy operands
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, $urandom, $urandom, "R3");

        // R2: clear beats enable
        step(1'b1, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
        step(1'b1, 1'b0, 32'h0000_0007, 32'h0000_0009, "R4");

        // R5: extreme operands
        step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, "R5");
        step(1'b1, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
        step(1'b1, 1'b0, 32'h7FFF_FFFF, 32'h8000_0000, "R5");

        // R8: multiplier patterns covering every digit value
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, '0, '0, "R2");
            step(1'b1, 1'b0, 32'hDEAD_BEEF, pats[i], "R8");
            step(1'b1, 1'b0, 32'h8000_0000, pats[i], "R8");
        end

        // R6: drive past the positive limit and wrap
        step(1'b1, 1'b1, '0, '0, "R2");
        for (int i = 0; i < 520; i++)
            step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, "R6");
        n_chk++;
        if (acc_o[71] !== 1'b1) begin
            n_bad++;
            $display("FAIL R6: acc=%h expected=negative after wrap", acc_o);
        end

        // R1: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        model = '0;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule